// File: doc/BRIEF.md
# DVS Set-Point Ramp Controller

This block produces the 5-bit target voltage code for one buck regulator channel. It stores three operating points: a normal code, a DVS code and a standby code. It picks one of them as the target from a DVS select pin and a standby condition. The standby condition is present only when two standby pins are both high, and it overrides the DVS pin.

The output code does not jump to a new target. It moves toward the target by one LSB at a time. The gap between steps is a programmable number of ticks from an external timebase enable. Every kind of target change uses this same rate: a DVS pin edge, entering or leaving standby, and a register write to the code that is currently selected. A busy flag stays high while the output code differs from the target. Software writes the three codes and the step-rate field through a single-cycle write port.

Top module: `dvs_ramp_ctrl`

## Requirements
- R1: When reset is asserted, the output code loads the normal-code reset value (12) at once, all registers return to their reset values (normal 12, DVS 12, standby 12, rate 0), and busy is low.
- R2: If standby is active, the target is the standby code, whatever level the DVS pin has. Otherwise the target is the DVS code when the DVS pin is 1 and the normal code when it is 0.
- R3: Standby is active only when both the primary and the secondary standby pins are 1. Either pin high on its own has no effect on target selection.
- R4: Each step moves the output code by exactly one LSB toward the target. Steps work both upward and downward.
- R5: The 2-bit rate field sets how many timebase ticks pass between steps: 0 gives 1 tick, 1 gives 2, 2 gives 4 and 3 gives 8. The code never changes in a cycle where tick_i is low.
- R6: busy_o is high exactly when the output code differs from the target. While busy_o is low, the output code holds its value.
- R7: A write that changes the normal code while the normal code is selected is ramped at the programmed rate. It is not applied in one jump.
- R8: If the target changes during a ramp, stepping continues from the present output code toward the new target, and the code does not restart from any set point.
- R9: The write address selects what is written: 0 is the normal code, 1 the DVS code, 2 the standby code and 3 the rate field (data bits 1:0). Writing a code that is not selected leaves the output code and busy_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select for the write |
| wr_data_i | input | 5 | Write data |
| stby_pri_i | input | 1 | Primary standby pin |
| stby_sec_i | input | 1 | Secondary standby pin |
| dvs_i | input | 1 | DVS select pin |
| tick_i | input | 1 | Timebase enable for stepping |
| code_o | output | 5 | Current output voltage code |
| busy_o | output | 1 | High while the code differs from the target |

## Verification
The bench cycles the pins through every standby and DVS combination, including cases where only one standby pin is high. A design that ORed the two standby pins, or that let the DVS pin override standby, would settle on the wrong code.

It counts ticks at every rate setting, including a rate change in the middle of a ramp. An interval decoded off by one would move the code one tick early or one tick late. It also holds tick_i low while the code is busy, which catches a design that steps on the clock instead of on ticks.

Two further tests cover ramp behaviour. A write to the normal code while that code is selected must not jump the output. A retarget in the middle of a ramp must reverse from the current code and not from a stored set point. A final test asserts reset during a ramp and expects the reset code to appear immediately, with no ramp.

// File: rtl/dvs_ramp_pkg.sv
package dvs_ramp_pkg;
  typedef enum logic [1:0] {
    ADDR_NORM = 2'd0,
    ADDR_DVS  = 2'd1,
    ADDR_STBY = 2'd2,
    ADDR_RATE = 2'd3
  } dvs_addr_e;

  typedef enum logic [1:0] {
    SEL_NORM = 2'd0,
    SEL_DVS  = 2'd1,
    SEL_STBY = 2'd2
  } dvs_sel_e;

  localparam int unsigned NUM_POINTS = 3;
endpackage

// File: rtl/dvs_setpoint_regs.sv
module dvs_setpoint_regs
  import dvs_ramp_pkg::*;
#(
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned RATE_W   = 2,
  parameter logic [CODE_W-1:0] RST_NORM = 5'd12,
  parameter logic [CODE_W-1:0] RST_DVS  = 5'd12,
  parameter logic [CODE_W-1:0] RST_STBY = 5'd12,
  parameter logic [RATE_W-1:0] RST_RATE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [CODE_W-1:0] wr_data_i,
  output logic [CODE_W-1:0] norm_code_o,
  output logic [CODE_W-1:0] dvs_code_o,
  output logic [CODE_W-1:0] stby_code_o,
  output logic [RATE_W-1:0] rate_o
);
  localparam logic [NUM_POINTS-1:0][CODE_W-1:0] RST_CODES = {RST_STBY, RST_DVS, RST_NORM};

  logic [NUM_POINTS-1:0][CODE_W-1:0] codes_q;
  logic [RATE_W-1:0]                 rate_q;

  for (genvar gi = 0; gi < NUM_POINTS; gi++) begin : g_point
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        codes_q[gi] <= RST_CODES[gi];
      end else if (wr_en_i && (wr_addr_i == 2'(gi))) begin
        codes_q[gi] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= RST_RATE;
    end else if (wr_en_i && (wr_addr_i == ADDR_RATE)) begin
      rate_q <= wr_data_i[RATE_W-1:0];
    end
  end

  assign norm_code_o = codes_q[ADDR_NORM];
  assign dvs_code_o  = codes_q[ADDR_DVS];
  assign stby_code_o = codes_q[ADDR_STBY];
  assign rate_o      = rate_q;
endmodule

// File: rtl/dvs_target_sel.sv
module dvs_target_sel
  import dvs_ramp_pkg::*;
#(
  parameter int unsigned CODE_W = 5
) (
  input  logic              stby_pri_i,
  input  logic              stby_sec_i,
  input  logic              dvs_i,
  input  logic [CODE_W-1:0] norm_code_i,
  input  logic [CODE_W-1:0] dvs_code_i,
  input  logic [CODE_W-1:0] stby_code_i,
  output dvs_sel_e          sel_o,
  output logic [CODE_W-1:0] target_o
);
  logic stby_eff;
  assign stby_eff = stby_pri_i & stby_sec_i;

  // standby outranks the DVS pin
  always_comb begin
    if (stby_eff)   sel_o = SEL_STBY;
    else if (dvs_i) sel_o = SEL_DVS;
    else            sel_o = SEL_NORM;
  end

  always_comb begin
    unique case (sel_o)
      SEL_STBY: target_o = stby_code_i;
      SEL_DVS:  target_o = dvs_code_i;
      default:  target_o = norm_code_i;
    endcase
  end
endmodule

// File: rtl/dvs_step_timer.sv
module dvs_step_timer #(
  parameter int unsigned RATE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              step_o
);
  // interval = 2**rate ticks, max 2**(2**RATE_W - 1)
  localparam int unsigned CNT_W = (2 ** RATE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  always_comb begin
    last = '0;
    for (int b = 0; b < CNT_W; b++) begin
      if (b < int'(rate_i)) last[b] = 1'b1;
    end
  end

  // >= keeps a shortened interval from wrapping after a rate change
  assign step_o = run_i & tick_i & (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= step_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dvs_ramp_core.sv
module dvs_ramp_core #(
  parameter int unsigned CODE_W = 5,
  parameter logic [CODE_W-1:0] RST_CODE = 5'd12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [CODE_W-1:0] target_i,
  output logic [CODE_W-1:0] code_o,
  output logic              busy_o
);
  logic [CODE_W-1:0] code_q;
  logic              go_up;

  assign go_up  = target_i > code_q;
  assign busy_o = code_q != target_i;
  assign code_o = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= RST_CODE;
    end else if (step_i && busy_o) begin
      code_q <= go_up ? code_q + 1'b1 : code_q - 1'b1;
    end
  end
endmodule

// File: rtl/dvs_ramp_ctrl.sv
module dvs_ramp_ctrl
  import dvs_ramp_pkg::*;
#(
  parameter int unsigned CODE_W = 5,
  parameter int unsigned RATE_W = 2,
  parameter logic [CODE_W-1:0] RST_NORM = 5'd12,
  parameter logic [CODE_W-1:0] RST_DVS  = 5'd12,
  parameter logic [CODE_W-1:0] RST_STBY = 5'd12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [CODE_W-1:0] wr_data_i,
  input  logic              stby_pri_i,
  input  logic              stby_sec_i,
  input  logic              dvs_i,
  input  logic              tick_i,
  output logic [CODE_W-1:0] code_o,
  output logic              busy_o
);
  logic [CODE_W-1:0] norm_code, dvs_code, stby_code, target_code;
  logic [RATE_W-1:0] rate;
  dvs_sel_e          sel;
  logic              step;

  dvs_setpoint_regs #(
    .CODE_W(CODE_W), .RATE_W(RATE_W),
    .RST_NORM(RST_NORM), .RST_DVS(RST_DVS), .RST_STBY(RST_STBY),
    .RST_RATE('0)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .norm_code_o(norm_code), .dvs_code_o(dvs_code),
    .stby_code_o(stby_code), .rate_o(rate)
  );

  dvs_target_sel #(.CODE_W(CODE_W)) u_sel (
    .stby_pri_i, .stby_sec_i, .dvs_i,
    .norm_code_i(norm_code), .dvs_code_i(dvs_code), .stby_code_i(stby_code),
    .sel_o(sel), .target_o(target_code)
  );

  dvs_step_timer #(.RATE_W(RATE_W)) u_timer (
    .clk_i, .rst_ni, .run_i(busy_o), .tick_i, .rate_i(rate), .step_o(step)
  );

  dvs_ramp_core #(.CODE_W(CODE_W), .RST_CODE(RST_NORM)) u_core (
    .clk_i, .rst_ni, .step_i(step), .target_i(target_code),
    .code_o, .busy_o
  );
endmodule

// File: rtl/dvs_ramp_chk.sv
module dvs_ramp_chk #(
  parameter int unsigned CODE_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stby_pri_i,
  input logic              stby_sec_i,
  input logic              tick_i,
  input logic [CODE_W-1:0] code_o,
  input logic              busy_o,
  input logic [CODE_W-1:0] target_code,
  input logic [CODE_W-1:0] stby_code
);
  AST_ONE_LSB_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != $past(code_o)) |->
      ((code_o == $past(code_o) + 1'b1) || (code_o == $past(code_o) - 1'b1))); // R4

  AST_STEP_TOWARD_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o > $past(code_o)) |-> ($past(target_code) > $past(code_o))); // R4

  AST_STEP_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != $past(code_o)) |-> $past(tick_i)); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(busy_o) |-> (code_o == $past(code_o))); // R6

  AST_STBY_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_pri_i && stby_sec_i) |-> (target_code == stby_code)); // R2
endmodule

bind dvs_ramp_ctrl dvs_ramp_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stby_pri_i(stby_pri_i), .stby_sec_i(stby_sec_i),
  .tick_i(tick_i), .code_o(code_o), .busy_o(busy_o),
  .target_code(target_code), .stby_code(stby_code)
);

// File: tb/tb_dvs_ramp_ctrl.sv
module tb_dvs_ramp_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 8;

  // {pri, sec, dvs, expected settled code} with normal=10, dvs=20, standby=4
  localparam logic [7:0] VEC [NVEC] = '{
    {3'b001, 5'd20}, {3'b111, 5'd4},  {3'b101, 5'd20}, {3'b010, 5'd10},
    {3'b110, 5'd4},  {3'b000, 5'd10}, {3'b001, 5'd20}, {3'b011, 5'd20}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [4:0] wr_data_i = '0;
  logic       stby_pri_i = 1'b0, stby_sec_i = 1'b0, dvs_i = 1'b0, tick_i = 1'b0;
  logic [4:0] code_o;
  logic       busy_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  dvs_ramp_ctrl dut (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .stby_pri_i, .stby_sec_i, .dvs_i, .tick_i, .code_o, .busy_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [4:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int prev;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 reset code", code_o, 12);
    chk("R1 reset busy", busy_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    wr(2'd1, 5'd20);
    wr(2'd2, 5'd4);
    wr(2'd0, 5'd10);            // R7 normal selected, ramp 12 -> 10
    chk("R7 no jump", code_o, 12);
    ticks(2);
    chk("R4 settle down", code_o, 10);
    chk("R6 idle", busy_o, 0);
    prev = 10;

    // table walk: R2/R3 selection, R4 steps, R6 busy
    for (int v = 0; v < NVEC; v++) begin
      int exp_code, nsteps;
      {stby_pri_i, stby_sec_i, dvs_i} = VEC[v][7:5];
      exp_code = int'(VEC[v][4:0]);
      nsteps = (exp_code > prev) ? exp_code - prev : prev - exp_code;
      @(negedge clk_i);
      chk("R6 busy on retarget", busy_o, int'(nsteps != 0));
      for (int s = 1; s <= nsteps; s++) begin
        ticks(1);
        chk("R4 one LSB", code_o, (exp_code > prev) ? prev + s : prev - s);
      end
      chk("R2 R3 settled code", code_o, exp_code);
      chk("R6 busy cleared", busy_o, 0);
      prev = exp_code;
    end

    // R5 interval per rate, code at 20, target 10
    wr(2'd3, 5'd2);
    dvs_i = 1'b0;
    @(negedge clk_i);
    ticks(3);
    chk("R5 rate2 before 4th tick", code_o, 20);
    ticks(1);
    chk("R5 rate2 at 4th tick", code_o, 19);
    repeat (20) @(negedge clk_i);
    chk("R5 no tick no step", code_o, 19);
    wr(2'd3, 5'd3);
    ticks(7);
    chk("R5 rate3 before 8th tick", code_o, 19);
    ticks(1);
    chk("R5 rate3 at 8th tick", code_o, 18);
    wr(2'd3, 5'd1);
    ticks(1);
    chk("R5 rate1 first tick", code_o, 18);
    ticks(1);
    chk("R5 rate1 second tick", code_o, 17);
    wr(2'd3, 5'd0);
    ticks(7);
    chk("R5 rate0 settle", code_o, 10);

    // R9 writes to unselected codes
    wr(2'd1, 5'd25);
    chk("R9 dvs write code", code_o, 10);
    chk("R9 dvs write busy", busy_o, 0);
    wr(2'd2, 5'd3);
    chk("R9 stby write busy", busy_o, 0);

    // R7 ramped normal write, R8 mid-ramp retarget
    wr(2'd0, 5'd15);
    chk("R7 busy after write", busy_o, 1);
    chk("R7 code held", code_o, 10);
    ticks(3);
    chk("R7 ramp up", code_o, 13);
    stby_pri_i = 1'b1; stby_sec_i = 1'b1;
    @(negedge clk_i);
    ticks(1);
    chk("R8 reverse from current", code_o, 12);
    ticks(9);
    chk("R8 reach standby", code_o, 3);
    chk("R8 busy clear", busy_o, 0);

    // R1 reset during ramp
    stby_pri_i = 1'b0; stby_sec_i = 1'b0;
    @(negedge clk_i);
    ticks(2);
    chk("R1 pre-reset ramp", code_o, 5);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset code", code_o, 12);
    chk("R1 async reset busy", busy_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset busy", busy_o, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule